// File: doc/BRIEF.md
# Quadrature Phase-Counting Timer Channel

This block is a 16-bit timer channel with two counting modes. In normal mode the counter steps up by one on every clock cycle in which an internal count enable is high. When the phase-counting bit of its mode register is set, the counter becomes an up/down counter driven by two external quadrature inputs. Every edge of either input, rising or falling, makes one count. The direction comes from which input leads, so the channel does four-times decoding of an incremental encoder.

Both external inputs pass through a two-stage synchroniser. An edge is found by comparing the newest synchronised sample with the one before it. If both inputs change in the same sample, the transition is illegal: the counter holds its value and a sticky error bit is set. The counter wraps modulo 2^16. A sticky wrap flag records overflow, and underflow as well unless a mode bit limits it to overflow only. Software reaches the counter, the mode register and the status bits through a small register bus. Writes take effect on the clock edge and reads are combinational. The five PWM select bits in the mode register are only stored.

Register map, on the 2-bit address: 0 is the counter. 1 is the mode register, with bit 7 always read as 1, bit 6 the phase-counting enable, bit 5 the overflow-only select and bits 4..0 the PWM selects. 2 is status, with bit 0 the wrap flag and bit 1 the step error. Address 3 reads 0.

Top module: `quad_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the mode register reads 0x0080 and status reads 0x0000, so the channel is in normal mode.
- R2: A write to address 1 stores bits 6..0 of the write data. Bit 7 always reads as 1, whatever was written to it. The PWM bits 4..0 read back as written and have no other effect.
- R3: With mode bit 6 = 0, the counter adds 1 on each clock edge where count_en is high. Changes on phase_a and phase_b do not alter the counter.
- R4: With mode bit 6 = 1, the counter adds 1 on each of these transitions: A rises while B is 0, B rises while A is 1, A falls while B is 1, or B falls while A is 0.
- R5: With mode bit 6 = 1, the counter subtracts 1 on each of these transitions: A rises while B is 1, B rises while A is 0, A falls while B is 0, or B falls while A is 1.
- R6: A pin change that is set up before rising edge k shows in the counter right after edge k+2, and not earlier.
- R7: With mode bit 6 = 1, if both inputs change in the same sample, the counter keeps its value and status bit 1 (step error) becomes 1. The bit stays 1 until it is cleared.
- R8: The counter wraps modulo 2^16. With mode bit 5 = 0, status bit 0 (wrap flag) is set both on overflow (0xFFFF to 0x0000) and on underflow (0x0000 to 0xFFFF).
- R9: With mode bit 5 = 1, an underflow leaves the wrap flag unchanged, and an overflow still sets it.
- R10: Writing address 2 with a 0 in bit 0 or bit 1 clears that status bit, and writing a 1 there leaves the bit as it is. A wrap in the same cycle as a clear leaves the flag set.
- R11: A counter write in the same cycle as a count event loads the written value. The lost count does not set the wrap flag.
- R12: With mode bit 6 = 1, count_en has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Internal count enable for normal mode |
| phase_a | input | 1 | Quadrature input A, asynchronous |
| phase_b | input | 1 | Quadrature input B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| wrap_flag | output | 1 | Sticky wrap flag (status bit 0) |
| step_err | output | 1 | Sticky illegal-transition flag (status bit 1) |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a counter write and a count event. The second is a status clear and a new wrap. Both are provoked in normal mode by holding count_en high with the counter at 0xFFFF while the write lands on the same edge. The first collision must leave the written value and a clear flag. The second must leave the flag set. Random quadrature walks with occasional illegal double toggles and counter rewrites are judged after each step against a bench model of the count, flag and error bits.

// File: rtl/quad_timer.sv
module quad_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             wrap_flag,
  output logic             step_err
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic                   a_prev, b_prev;
  logic [CNT_W-1:0]       cnt_q;
  logic [6:0]             mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], phase_a};
      sync_b <= {sync_b[SYNC_STAGES-2:0], phase_b};
      a_prev <= sync_a[SYNC_STAGES-1];
      b_prev <= sync_b[SYNC_STAGES-1];
    end
  end

  wire a_cur    = sync_a[SYNC_STAGES-1];
  wire b_cur    = sync_b[SYNC_STAGES-1];
  wire a_chg    = a_cur ^ a_prev;
  wire b_chg    = b_cur ^ b_prev;
  wire phase_on = mode_q[6];
  wire ovf_only = mode_q[5];

  wire legal_step = phase_on & (a_chg ^ b_chg);
  wire illegal    = phase_on & a_chg & b_chg;
  wire step_up    = a_chg ? (a_cur ^ b_cur) : (b_cur ~^ a_cur);

  wire count_up = phase_on ? (legal_step & step_up) : count_en;
  wire count_dn = legal_step & ~step_up;

  wire cnt_wr  = wr_en & (addr == 2'd0);
  wire mode_wr = wr_en & (addr == 2'd1);
  wire stat_wr = wr_en & (addr == 2'd2);

  wire ovf      = count_up & (cnt_q == FULL);
  wire unf      = count_dn & (cnt_q == ZERO);
  wire wrap_set = ~cnt_wr & (ovf | (unf & ~ovf_only));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      mode_q    <= '0;
      wrap_flag <= 1'b0;
      step_err  <= 1'b0;
    end else begin
      if (cnt_wr)        cnt_q <= wdata;
      else if (count_up) cnt_q <= cnt_q + ONE;
      else if (count_dn) cnt_q <= cnt_q - ONE;
      if (mode_wr) mode_q <= wdata[6:0];
      wrap_flag <= wrap_set | (wrap_flag & ~(stat_wr & ~wdata[0]));
      step_err  <= illegal  | (step_err  & ~(stat_wr & ~wdata[1]));
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cnt_q;
      2'd1:    rdata = {{(CNT_W-8){1'b0}}, 1'b1, mode_q};
      2'd2:    rdata = {{(CNT_W-2){1'b0}}, step_err, wrap_flag};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/quad_timer_chk.sv
module quad_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             count_en,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] rdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [6:0]       mode_q,
  input logic             wrap_flag,
  input logic             step_err,
  input logic             a_chg,
  input logic             b_chg
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  wire cnt_wr = wr_en && addr == 2'd0;

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(wdata));

  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[6] && a_chg && b_chg && !cnt_wr |=> $stable(cnt_q) && step_err);

  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[6] && !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE
                              || cnt_q == $past(cnt_q) - ONE));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[6] && !count_en && !cnt_wr |=> $stable(cnt_q));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_flag && !(wr_en && addr == 2'd2 && !wdata[0]) |=> wrap_flag);

  p_reserved_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd1 |-> rdata[7]);

  p_no_underflow_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[5] && !wrap_flag && cnt_q == '0 |=> !wrap_flag);
endmodule

bind quad_timer quad_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .cnt_q(cnt_q), .mode_q(mode_q),
  .wrap_flag(wrap_flag), .step_err(step_err), .a_chg(a_chg), .b_chg(b_chg)
);

// File: tb/test_quad_timer.sv
`timescale 1ns/1ps
module test_quad_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic        pa = 1'b0, pb = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wrap_flag, step_err;

  int n_checks = 0, n_fail = 0;
  logic [15:0] m_cnt;
  bit m_wrap, m_err, m_ovf_only;

  always #2.5 clk = ~clk;

  quad_timer i_quad_timer (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .phase_a(pa), .phase_b(pb),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .wrap_flag(wrap_flag), .step_err(step_err)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // +1 up, -1 down, 0 none, 2 illegal, from the transition lists of R4/R5
  function automatic int qdir(bit ao, bit bo, bit an, bit bn);
    if (ao != an && bo != bn) return 2;
    if (ao == an && bo == bn) return 0;
    if (ao != an) begin
      if (an && !bo) return 1;
      if (!an && bo) return 1;
      return -1;
    end
    if (bn && ao) return 1;
    if (!bn && !ao) return 1;
    return -1;
  endfunction

  task automatic model_step(bit an, bit bn);
    int d = qdir(pa, pb, an, bn);
    if (d == 2) m_err = 1;
    else if (d == 1) begin
      if (m_cnt == 16'hFFFF) m_wrap = 1;
      m_cnt = m_cnt + 16'd1;
    end else if (d == -1) begin
      if (m_cnt == 16'h0000 && !m_ovf_only) m_wrap = 1;
      m_cnt = m_cnt - 16'd1;
    end
  endtask

  task automatic qstep(bit an, bit bn);
    model_step(an, bn);
    @(negedge clk); pa = an; pb = bn;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #500us;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int r;
    r = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 counter", v, 16'h0000);
    rd(2'd1, v); chk("R1 mode", v, 16'h0080);
    rd(2'd2, v); chk("R1 status", v, 16'h0000);

    // R2 mode register storage
    wr(2'd1, 16'h009F); rd(2'd1, v); chk("R2 pwm bits", v, 16'h009F);
    wr(2'd1, 16'h0000); rd(2'd1, v); chk("R2 reserved reads 1", v, 16'h0080);
    rd(2'd0, v); chk("R2 pwm no effect", v, 16'h0000);

    // R3 normal counting, pins ignored
    @(negedge clk); count_en = 1'b1;
    repeat (5) @(negedge clk); count_en = 1'b0;
    rd(2'd0, v); chk("R3 five counts", v, 16'h0005);
    @(negedge clk); pa = 1'b1; repeat (2) @(negedge clk); pb = 1'b1;
    repeat (4) @(negedge clk); pa = 1'b0; pb = 1'b0; repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R3 pins ignored", v, 16'h0005);

    // R4/R5/R6 phase mode
    wr(2'd0, 16'h0100); wr(2'd1, 16'h0040);
    m_cnt = 16'h0100; m_wrap = 0; m_err = 0; m_ovf_only = 0;
    addr = 2'd0;
    @(negedge clk); pa = 1'b1;              // A rises, B low: up
    @(negedge clk); #1; chk("R6 after edge k", rdata, 16'h0100);
    @(negedge clk); #1; chk("R6 after edge k+1", rdata, 16'h0100);
    @(negedge clk); #1; chk("R6 after edge k+2", rdata, 16'h0101);
    pa = 1'b0; repeat (3) @(negedge clk);    // A falls, B low: down
    rd(2'd0, v); chk("R5 A falls B low", v, 16'h0100);
    m_cnt = 16'h0100;
    qstep(1, 0); qstep(1, 1); qstep(0, 1); qstep(0, 0);
    rd(2'd0, v); chk("R4 forward cycle", v, 16'h0104);
    qstep(0, 1); qstep(1, 1); qstep(1, 0); qstep(0, 0);
    rd(2'd0, v); chk("R5 reverse cycle", v, 16'h0100);

    // R12 count_en ignored in phase mode
    @(negedge clk); count_en = 1'b1; repeat (6) @(negedge clk); count_en = 1'b0;
    rd(2'd0, v); chk("R12 count_en ignored", v, 16'h0100);

    // R7 illegal transition
    qstep(1, 1);
    rd(2'd0, v); chk("R7 hold on double change", v, 16'h0100);
    rd(2'd2, v); chk("R7 error bit", v, 16'h0002);
    wr(2'd2, 16'h0001); rd(2'd2, v); chk("R10 clear error only", v, 16'h0000);
    m_err = 0;

    // R8 underflow with bit5=0
    wr(2'd0, 16'h0000); m_cnt = 0;
    qstep(0, 1);   // A falls while B high? here A=1,B=1 -> A falls B high: up
    wr(2'd0, 16'h0000); m_cnt = 0;
    qstep(0, 0);   // B falls while A low: up
    wr(2'd0, 16'h0000); m_cnt = 0;
    qstep(0, 1);   // B rises while A low: down -> underflow
    rd(2'd0, v); chk("R8 underflow wraps", v, 16'hFFFF);
    rd(2'd2, v); chk("R8 underflow flag", v, 16'h0001);
    wr(2'd2, 16'h0000); m_wrap = 0;

    // R9 overflow-only
    wr(2'd1, 16'h0060); m_ovf_only = 1;
    wr(2'd0, 16'h0000); m_cnt = 0;
    qstep(0, 0);   // B falls while A low: up
    wr(2'd0, 16'h0000); m_cnt = 0;
    qstep(0, 1);   // down -> underflow
    rd(2'd0, v); chk("R9 underflow wraps", v, 16'hFFFF);
    rd(2'd2, v); chk("R9 no flag on underflow", v, 16'h0000);
    qstep(1, 1);   // B high, A rises: down
    wr(2'd0, 16'hFFFF); m_cnt = 16'hFFFF;
    qstep(0, 1);   // A falls while B high: up -> overflow
    rd(2'd0, v); chk("R9 overflow wraps", v, 16'h0000);
    rd(2'd2, v); chk("R9 flag on overflow", v, 16'h0001);

    // R8/R10/R11 collisions in normal mode
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'hFFFF);
    @(negedge clk); count_en = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 16'h0005;
    @(negedge clk); count_en = 1'b0; wr_en = 1'b0;
    rd(2'd0, v); chk("R11 write beats count", v, 16'h0005);
    rd(2'd2, v); chk("R11 no flag from lost count", v, 16'h0000);
    wr(2'd0, 16'hFFFF);
    @(negedge clk); count_en = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = 16'h0000;
    @(negedge clk); count_en = 1'b0; wr_en = 1'b0;
    rd(2'd0, v); chk("R8 overflow wraps", v, 16'h0000);
    rd(2'd2, v); chk("R10 set wins over clear", v, 16'h0001);
    wr(2'd2, 16'h0003); rd(2'd2, v); chk("R10 write 1 keeps", v, 16'h0001);
    wr(2'd2, 16'h0000); rd(2'd2, v); chk("R10 write 0 clears", v, 16'h0000);

    // random quadrature walk, R4/R5/R7/R8
    wr(2'd1, 16'h0040); m_ovf_only = 0; m_wrap = 0; m_err = 0;
    wr(2'd0, 16'h0003); m_cnt = 16'h0003;
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 16;
      if (sel == 0) qstep(~pa, ~pb);
      else if (sel == 1) begin
        logic [15:0] d = (($urandom % 2) == 0) ? 16'($urandom % 4) : 16'hFFFF - 16'($urandom % 4);
        wr(2'd0, d); m_cnt = d;
      end else if (sel == 2) begin
        wr(2'd2, 16'h0000); m_wrap = 0; m_err = 0;
      end else if (sel < 9) qstep(~pa, pb);
      else qstep(pa, ~pb);
      rd(2'd0, v); chk("R4/R5 random count", v, m_cnt);
      rd(2'd2, v); chk("R7/R8 random status", v, {14'd0, m_err, m_wrap});
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule